// File: doc/BRIEF.md
# Host command receive path

This block takes command words from a host through a 32-bit synchronous FIFO-style USB bridge and hands them to the 100 MHz system clock domain. A read machine clocked by the bridge clock waits until the bridge's active-low receive-available flag goes low. It then enables the bridge's bus drivers for one cycle, strobes one word in, releases the bus, and holds the captured command in a process phase. The word's byte-enable lanes are honoured: a lane marked unused reads as zero.

Each captured word is shown as a raw word and also split into an opcode, an address and a value. A one-cycle strobe marks each new command. The strobe crosses into the system domain as a toggle, so every command yields exactly one decoder update. The decoder keeps the radar mode and trigger, which feed the receiver's mode controller, plus a detection threshold and a stream-control field. A transmit-ownership input keeps the read machine idle while write traffic has the bus. The bridge-domain reset passes through its own two-stage synchronizer.

Top module: `hostcmd_rx`

## Requirements
- R1: After reset, oe_n and rd_n are high, cmd_valid is low, host_mode, host_trigger and stream_ctl are zero, and det_threshold equals THRESH_INIT (default 0x0080).
- R2: The machine leaves idle only in a cycle where rxf_n is low and tx_hold is low. oe_n is low for one full bridge cycle before rd_n goes low.
- R3: rd_n is low for exactly one bridge cycle per word read.
- R4: oe_n stays low for exactly two bridge cycles per word, and it rises in the cycle after the rd_n-low cycle.
- R5: The captured word is bus_data as sampled at the end of the rd_n-low cycle. Byte lane i is bits [8i+7:8i]; when bus_be[i] is 0, that lane reads as zero.
- R6: cmd_valid is high for one cycle, two bridge cycles after the rd_n-low cycle. In that same cycle cmd_data shows the new word, with cmd_opcode = bits [31:24], cmd_addr = bits [23:16] and cmd_value = bits [15:0].
- R7: cmd_data and its fields do not change except in a cmd_valid cycle. After a strobe, oe_n stays high for at least HOLD_CYCLES (default 8) bridge cycles.
- R8: While tx_hold is high, or rxf_n is high, an idle machine does not assert oe_n.
- R9: Every word read causes exactly one decoder update in the system domain, including words read back-to-back. No command is lost or repeated.
- R10: Opcode 0x01 sets host_mode to value[1:0]. Opcode 0x02 sets host_trigger to value[0]. Opcode 0x03 sets det_threshold to value[15:0]. Opcode 0x04 sets stream_ctl to value[2:0].
- R11: A command with any other opcode, including one made zero by byte masking, leaves all four system registers unchanged.
- R12: Words that wait while tx_hold is asserted are read once it drops. Commands are applied in the order they were received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bridge clock |
| bus_rst_n | input | 1 | Raw active-low reset for the bridge domain; synchronized inside |
| clk_sys | input | 1 | 100 MHz system clock |
| sys_rst_n | input | 1 | Synchronous active-low reset for the system domain |
| rxf_n | input | 1 | Low while the bridge holds a word to be read |
| tx_hold | input | 1 | High while write traffic owns the bus |
| bus_data | input | 32 | Data word from the bridge |
| bus_be | input | 4 | Byte-lane enables for bus_data |
| oe_n | output | 1 | Active-low bus output enable to the bridge |
| rd_n | output | 1 | Active-low read strobe to the bridge |
| cmd_data | output | 32 | Last captured raw word (after masking) |
| cmd_valid | output | 1 | One-cycle new-command strobe in the bridge domain |
| cmd_opcode | output | 8 | Opcode field of cmd_data |
| cmd_addr | output | 8 | Address field of cmd_data |
| cmd_value | output | 16 | Value field of cmd_data |
| host_mode | output | 2 | Radar mode for the receiver's mode controller |
| host_trigger | output | 1 | Trigger for the receiver's mode controller |
| det_threshold | output | 16 | Detection threshold |
| stream_ctl | output | 3 | Stream-control field |

## Verification
The assertions assume that both resets are held together for several cycles of each clock. They also assume the bridge never changes bus_data or bus_be during the rd_n-low cycle, and that HOLD_CYCLES bridge cycles last longer than the synchronizer delay plus one system cycle. The bench keeps within these limits. It drives both resets for ten system cycles and uses a 250 MHz bridge clock against the 100 MHz system clock. It presents the head of its word queue on the bus and removes that word only after the read strobe ends. It changes tx_hold and queue contents only on falling edges.

// File: rtl/hostcmd_pkg.sv
// Shared types and constants for the host command receive path.
// Assumes a 32-bit word laid out as opcode, address and value.
package hostcmd_pkg;
    localparam int WORD_W = 32;
    localparam int BE_W   = WORD_W / 8;
    localparam int OPC_W  = 8;
    localparam int ADR_W  = 8;
    localparam int VAL_W  = 16;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_OE,
        RS_READ,
        RS_RELEASE,
        RS_PROCESS
    } rd_state_e;

    typedef struct packed {
        logic [OPC_W-1:0] opcode;
        logic [ADR_W-1:0] addr;
        logic [VAL_W-1:0] value;
    } cmd_word_t;

    localparam logic [OPC_W-1:0] OPC_MODE   = 8'h01;
    localparam logic [OPC_W-1:0] OPC_TRIG   = 8'h02;
    localparam logic [OPC_W-1:0] OPC_THRESH = 8'h03;
    localparam logic [OPC_W-1:0] OPC_STREAM = 8'h04;
endpackage

// File: rtl/hc_reset_sync.sv
// Reset synchronizer: passes a raw active-low reset into the bridge
// domain through STAGES flops. Assumes the raw reset lasts several cycles.
module hc_reset_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic raw_rst_n,
    output logic rst_n
);
    logic [STAGES-1:0] chain;

    // Shift the raw reset level through the chain.
    always_ff @(posedge clk) begin
        chain <= {chain[STAGES-2:0], raw_rst_n};
    end

    assign rst_n = chain[STAGES-1];
endmodule

// File: rtl/hc_read_fsm.sv
// Bridge-domain read machine: idle, enable output, read, release, process.
// Captures one masked word per pass and holds it until the next strobe.
// Assumes the bridge keeps bus_data stable during the read cycle.
module hc_read_fsm
    import hostcmd_pkg::*;
#(
    parameter int HOLD_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxf_n,
    input  logic              tx_hold,
    input  logic [WORD_W-1:0] bus_data,
    input  logic [BE_W-1:0]   bus_be,
    output logic              oe_n,
    output logic              rd_n,
    output cmd_word_t         cmd_word,
    output logic              cmd_valid
);
    localparam int CNT_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);

    rd_state_e         state, state_nx;
    logic [WORD_W-1:0] masked;
    logic [WORD_W-1:0] read_q;
    cmd_word_t         cmd_q;
    logic [CNT_W-1:0]  cnt;

    // Zero every byte lane whose enable is low.
    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        assign masked[8*g +: 8] = bus_be[g] ? bus_data[8*g +: 8] : 8'h00;
    end

    // Next-state selection for the read handshake.
    always_comb begin
        state_nx = state;
        unique case (state)
            RS_IDLE:    if (!rxf_n && !tx_hold) state_nx = RS_OE;
            RS_OE:      state_nx = RS_READ;
            RS_READ:    state_nx = RS_RELEASE;
            RS_RELEASE: state_nx = RS_PROCESS;
            RS_PROCESS: if (cnt == CNT_LAST) state_nx = RS_IDLE;
            default:    state_nx = RS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RS_IDLE;
        else        state <= state_nx;
    end

    // Process-phase dwell counter.
    always_ff @(posedge clk) begin
        if (!rst_n || state != RS_PROCESS) cnt <= '0;
        else                               cnt <= cnt + 1'b1;
    end

    // Capture the bus word at the end of the read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                 read_q <= '0;
        else if (state == RS_READ)  read_q <= masked;
    end

    // Publish the command once the bus is released.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cmd_q <= '0;
        else if (state == RS_RELEASE) cmd_q <= cmd_word_t'(read_q);
    end

    assign oe_n      = !(state == RS_OE || state == RS_READ);
    assign rd_n      = (state != RS_READ);
    assign cmd_word  = cmd_q;
    assign cmd_valid = (state == RS_PROCESS) && (cnt == '0);

    initial begin
        assert (HOLD_CYCLES >= 2) else $error("HOLD_CYCLES below 2");
    end

    p_oe_leads_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> (!oe_n && $past(!oe_n)));
    p_idle_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_IDLE && (rxf_n || tx_hold)) |=> oe_n);
    p_rd_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |=> rd_n);
    p_oe_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && !rd_n) |=> oe_n);
    p_valid_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(!rd_n, 2));
    p_fields_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> $stable(cmd_word));
    p_no_early_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> oe_n);
    p_hold_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n && tx_hold && state == RS_IDLE) |=> oe_n);
endmodule

// File: rtl/hc_toggle_sync.sv
// Toggle crossing for a single-cycle strobe: the source flips a level,
// the destination samples it through STAGES flops and makes an edge pulse.
// Assumes strobes are spaced wider than the destination's latency.
module hc_toggle_sync #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);
    logic            src_tgl;
    logic [STAGES:0] chain;

    // Flip the source level once per strobe.
    always_ff @(posedge src_clk) begin
        if (!src_rst_n)     src_tgl <= 1'b0;
        else if (src_pulse) src_tgl <= ~src_tgl;
    end

    // Sample the level in the destination domain.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) chain <= '0;
        else            chain <= {chain[STAGES-1:0], src_tgl};
    end

    assign dst_pulse = chain[STAGES] ^ chain[STAGES-1];

    p_single_pulse_r9: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        dst_pulse |=> !dst_pulse);
endmodule

// File: rtl/hc_cmd_decoder.sv
// System-domain register decoder. On each crossed strobe it looks at the
// held opcode and value. Assumes those stay stable around the strobe.
module hc_cmd_decoder
    import hostcmd_pkg::*;
#(
    parameter int              THRESH_W    = 16,
    parameter int              STREAM_W    = 3,
    parameter logic [THRESH_W-1:0] THRESH_INIT = 16'h0080
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                upd,
    input  logic [OPC_W-1:0]    opcode,
    input  logic [VAL_W-1:0]    value,
    output logic [1:0]          mode,
    output logic                trigger,
    output logic [THRESH_W-1:0] threshold,
    output logic [STREAM_W-1:0] stream
);
    logic known;
    assign known = (opcode == OPC_MODE) || (opcode == OPC_TRIG) ||
                   (opcode == OPC_THRESH) || (opcode == OPC_STREAM);

    // Update the register the opcode selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= '0;
            trigger   <= 1'b0;
            threshold <= THRESH_INIT;
            stream    <= '0;
        end else if (upd) begin
            unique case (opcode)
                OPC_MODE:   mode      <= value[1:0];
                OPC_TRIG:   trigger   <= value[0];
                OPC_THRESH: threshold <= value[THRESH_W-1:0];
                OPC_STREAM: stream    <= value[STREAM_W-1:0];
                default:    ;
            endcase
        end
    end

    p_unknown_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !known) |=> $stable({mode, trigger, threshold, stream}));
    p_quiet_without_upd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable({mode, trigger, threshold, stream}));
endmodule

// File: rtl/hostcmd_rx.sv
// Top of the host command receive path: bridge-domain read machine,
// toggle crossing of its strobe, and the system-domain decoder.
// Assumes HOLD_CYCLES bridge cycles exceed the crossing latency.
module hostcmd_rx
    import hostcmd_pkg::*;
#(
    parameter int HOLD_CYCLES = 8,
    parameter int SYNC_STAGES = 2,
    parameter int THRESH_W    = 16,
    parameter int STREAM_W    = 3,
    parameter logic [THRESH_W-1:0] THRESH_INIT = 16'h0080
) (
    input  logic                clk_bus,
    input  logic                bus_rst_n,
    input  logic                clk_sys,
    input  logic                sys_rst_n,
    input  logic                rxf_n,
    input  logic                tx_hold,
    input  logic [31:0]         bus_data,
    input  logic [3:0]          bus_be,
    output logic                oe_n,
    output logic                rd_n,
    output logic [31:0]         cmd_data,
    output logic                cmd_valid,
    output logic [7:0]          cmd_opcode,
    output logic [7:0]          cmd_addr,
    output logic [15:0]         cmd_value,
    output logic [1:0]          host_mode,
    output logic                host_trigger,
    output logic [THRESH_W-1:0] det_threshold,
    output logic [STREAM_W-1:0] stream_ctl
);
    logic      brst_n;
    cmd_word_t word;
    logic      sys_upd;

    hc_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
        .clk(clk_bus), .raw_rst_n(bus_rst_n), .rst_n(brst_n)
    );

    hc_read_fsm #(.HOLD_CYCLES(HOLD_CYCLES)) u_fsm (
        .clk(clk_bus), .rst_n(brst_n), .rxf_n(rxf_n), .tx_hold(tx_hold),
        .bus_data(bus_data), .bus_be(bus_be), .oe_n(oe_n), .rd_n(rd_n),
        .cmd_word(word), .cmd_valid(cmd_valid)
    );

    hc_toggle_sync #(.STAGES(SYNC_STAGES)) u_xing (
        .src_clk(clk_bus), .src_rst_n(brst_n), .src_pulse(cmd_valid),
        .dst_clk(clk_sys), .dst_rst_n(sys_rst_n), .dst_pulse(sys_upd)
    );

    hc_cmd_decoder #(
        .THRESH_W(THRESH_W), .STREAM_W(STREAM_W), .THRESH_INIT(THRESH_INIT)
    ) u_dec (
        .clk(clk_sys), .rst_n(sys_rst_n), .upd(sys_upd),
        .opcode(word.opcode), .value(word.value),
        .mode(host_mode), .trigger(host_trigger),
        .threshold(det_threshold), .stream(stream_ctl)
    );

    assign cmd_data   = word;
    assign cmd_opcode = word.opcode;
    assign cmd_addr   = word.addr;
    assign cmd_value  = word.value;
endmodule

// File: tb/tb_hostcmd_rx.sv
module tb_hostcmd_rx;
    localparam int HOLD = 8;

    logic        clk_bus = 1'b0, clk_sys = 1'b0;
    logic        bus_rst_n = 1'b0, sys_rst_n = 1'b0;
    logic        rxf_n = 1'b1, tx_hold = 1'b0;
    logic [31:0] bus_data = '0;
    logic [3:0]  bus_be = '0;
    logic        oe_n, rd_n, cmd_valid, host_trigger;
    logic [31:0] cmd_data;
    logic [7:0]  cmd_opcode, cmd_addr;
    logic [15:0] cmd_value, det_threshold;
    logic [1:0]  host_mode;
    logic [2:0]  stream_ctl;

    hostcmd_rx #(.HOLD_CYCLES(HOLD)) dut (
        .clk_bus(clk_bus), .bus_rst_n(bus_rst_n), .clk_sys(clk_sys),
        .sys_rst_n(sys_rst_n), .rxf_n(rxf_n), .tx_hold(tx_hold),
        .bus_data(bus_data), .bus_be(bus_be), .oe_n(oe_n), .rd_n(rd_n),
        .cmd_data(cmd_data), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
        .cmd_addr(cmd_addr), .cmd_value(cmd_value), .host_mode(host_mode),
        .host_trigger(host_trigger), .det_threshold(det_threshold),
        .stream_ctl(stream_ctl)
    );

    always #2 clk_bus = ~clk_bus;   // 250 MHz bridge clock
    always #5 clk_sys = ~clk_sys;   // 100 MHz system clock

    int checks = 0, errors = 0, cyc = 0;
    logic run_cmp = 1'b0;
    logic [31:0] qd[$];
    logic [3:0]  qb[$];
    logic [1:0]  e_mode = '0;
    logic        e_trig = 1'b0;
    logic [15:0] e_thr = 16'h0080;
    logic [2:0]  e_str = '0;

    // Behavioural reference of the bridge-side handshake.
    int          m_st = 0, m_cnt = 0;
    logic [31:0] m_word = '0, m_cmd = '0;

    function automatic logic [31:0] bmask(logic [31:0] d, logic [3:0] be);
        logic [31:0] r = '0;
        for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = d[8*i +: 8];
        return r;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk_bus) begin
        if (!bus_rst_n) begin
            m_st <= 0; m_cnt <= 0; m_word <= '0; m_cmd <= '0;
        end else begin
            case (m_st)
                0: if (!rxf_n && !tx_hold) m_st <= 1;
                1: m_st <= 2;
                2: begin m_word <= bmask(bus_data, bus_be); m_st <= 3; end
                3: begin m_cmd <= m_word; m_st <= 4; m_cnt <= 0; end
                default: begin
                    if (m_cnt == HOLD - 1) m_st <= 0;
                    m_cnt <= m_cnt + 1;
                end
            endcase
        end
    end

    // Per-cycle comparison against the reference (R2..R7).
    always @(negedge clk_bus) begin
        if (run_cmp) begin
            chk("R2/R4 oe_n", {31'b0, oe_n}, {31'b0, !(m_st == 1 || m_st == 2)});
            chk("R3 rd_n", {31'b0, rd_n}, {31'b0, m_st != 2});
            chk("R6 cmd_valid", {31'b0, cmd_valid}, {31'b0, m_st == 4 && m_cnt == 0});
            chk("R5 cmd_data", cmd_data, m_cmd);
            chk("R7 fields", {cmd_opcode, cmd_addr, cmd_value}, m_cmd);
        end
    end

    // Bridge model: present queue head, drop it after the read strobe.
    logic rd_seen = 1'b0;
    always @(negedge clk_bus) begin
        if (rd_seen) begin
            void'(qd.pop_front());
            void'(qb.pop_front());
        end
        rd_seen  <= !rd_n;
        rxf_n    <= (qd.size() == 0) || (rd_seen && qd.size() == 1);
        bus_data <= (qd.size() > (rd_seen ? 1 : 0)) ? qd[rd_seen ? 1 : 0] : '0;
        bus_be   <= (qb.size() > (rd_seen ? 1 : 0)) ? qb[rd_seen ? 1 : 0] : '0;
    end

    always @(posedge clk_bus) begin
        cyc++;
        if (cyc > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    task automatic push(logic [31:0] d, logic [3:0] be);
        logic [31:0] w = bmask(d, be);
        qd.push_back(d);
        qb.push_back(be);
        case (w[31:24])
            8'h01: e_mode = w[1:0];
            8'h02: e_trig = w[0];
            8'h03: e_thr  = w[15:0];
            8'h04: e_str  = w[2:0];
            default: ;
        endcase
    endtask

    task automatic drain();
        do @(negedge clk_bus); while (qd.size() != 0 || m_st != 0);
        repeat (6) @(negedge clk_sys);
    endtask

    task automatic chk_regs(string tag);
        chk({tag, " host_mode"}, {30'b0, host_mode}, {30'b0, e_mode});
        chk({tag, " host_trigger"}, {31'b0, host_trigger}, {31'b0, e_trig});
        chk({tag, " det_threshold"}, {16'b0, det_threshold}, {16'b0, e_thr});
        chk({tag, " stream_ctl"}, {29'b0, stream_ctl}, {29'b0, e_str});
    endtask

    initial begin
        repeat (10) @(negedge clk_sys);
        bus_rst_n = 1'b1;
        sys_rst_n = 1'b1;
        repeat (4) @(negedge clk_bus);
        run_cmp = 1'b1;
        chk_regs("R1 reset");
        chk("R1 cmd_valid", {31'b0, cmd_valid}, 32'd0);

        @(negedge clk_bus);
        push(32'h0133_0002, 4'hF);          // R10 single command, mode
        drain();
        chk_regs("R10 single");

        @(negedge clk_bus);                 // R9 back-to-back, all four opcodes
        push(32'h0300_1234, 4'hF);
        push(32'h0410_0005, 4'hF);
        push(32'h0220_0001, 4'hF);
        push(32'h0130_0003, 4'hF);
        drain();
        chk_regs("R9 back-to-back");

        @(negedge clk_bus);
        push(32'h0300_ABCD, 4'b1101);       // R5 masked value byte
        drain();
        chk_regs("R5 byte mask");
        push(32'h0400_0007, 4'b0111);       // R11 opcode lane masked to zero
        push(32'h7F00_FFFF, 4'hF);          // R11 unknown opcode
        drain();
        chk_regs("R11 ignored");

        @(negedge clk_bus);
        tx_hold = 1'b1;                     // R8 write traffic owns bus
        push(32'h0100_0001, 4'hF);
        repeat (30) @(negedge clk_bus);
        chk("R8 word still pending", qd.size(), 32'd1);
        chk("R8 mode unchanged", {30'b0, host_mode}, 32'd3);
        tx_hold = 1'b0;
        drain();
        chk_regs("R8 after release");

        @(negedge clk_bus);                 // R12 reads interleaved with writes
        push(32'h0300_0042, 4'hF);
        push(32'h0200_0000, 4'hF);
        push(32'h0400_0002, 4'hF);
        push(32'h0300_0099, 4'hF);
        for (int i = 0; i < 30; i++) begin
            tx_hold = (i % 2) == 0;
            repeat (7) @(negedge clk_bus);
        end
        tx_hold = 1'b0;
        drain();
        chk_regs("R12 interleave");

        run_cmp = 1'b0;
        summary();
    end
endmodule